// File: doc/BRIEF.md
# Window Comparator Error Decoder with Phase Clamp

This block sits between a small bank of window comparators and a digital PWM controller. The comparators compare the sensed output against thresholds placed at equal steps above and below the reference. Their outputs arrive asynchronously. The block synchronizes them and counts the comparators that are set. It turns that count into a signed error word, so the controller never sees an absolute value. When the controller strobes `sample_i`, the error word is captured. When the sensed quantity is outside the window, the error word saturates to the extreme code of its width.

The two edge comparators are watched on every clock, which is much faster than the controller sample rate. If the sensed quantity goes above the window, every phase output is forced low. If it goes below the window, every phase output is forced high. When the quantity comes back inside the window, the forced level stays until the next PWM period boundary. From that boundary on, the phase outputs follow the modulator again. The switching period is not changed by any of this.

Top module: `wadc_err_clamp`

## Requirements
- R1: After reset `err_o` is 0 and `pwm_o` follows `pwm_i`.
- R2: The comparators are ordered so that `cmp_i[0]` has the lowest threshold and `cmp_i[NCMP-1]` the highest. Bit k is 1 when the sensed quantity is above threshold k. The sensed quantity is inside the window when `cmp_i[0]`=1 and `cmp_i[NCMP-1]`=0. Inside the window, the edge of `sample_i` captures `err_o` = NCMP/2 minus the number of set bits. With `sample_i` low, `err_o` holds its value.
- R3: A non-monotonic code is decoded by counting its ones, wherever the ones are placed. For example, 6'b010101 gives 0.
- R4: When `cmp_i[NCMP-1]`=1, the sensed quantity is above the window, and a sample stores the most negative code, -2^(ERR_W-1). This case takes priority over every other case.
- R5: When `cmp_i[0]`=0 and `cmp_i[NCMP-1]`=0, the sensed quantity is below the window, and a sample stores the most positive code, 2^(ERR_W-1)-1.
- R6: Above the window, all bits of `pwm_o` are 0 from the third clock edge after the comparator change. This does not depend on `sample_i`.
- R7: Below the window, all bits of `pwm_o` are 1 from the third clock edge after the comparator change.
- R8: After a return inside the window, `pwm_o` keeps the forced level until `period_i` is high. In the cycle where `period_i` is high, `pwm_o` equals `pwm_i`, and it keeps following `pwm_i` after that.
- R9: The block moves directly between the forced-off and forced-on states when the sensed quantity crosses the whole window.
- R10: While not clamped, `pwm_o` equals `pwm_i` in the same cycle, and `period_i` has no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock, also the rate at which the edge comparators are watched |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmp_i | input | NCMP | Raw asynchronous comparator outputs, lowest threshold at bit 0 |
| sample_i | input | 1 | Controller sample strobe that captures the error word |
| pwm_i | input | NPH | Phase drive signals from the modulator |
| period_i | input | 1 | Strobe that marks the start of a PWM period |
| err_o | output | ERR_W | Signed error word (reference minus sensed, in comparator steps) |
| pwm_o | output | NPH | Phase drive signals after the clamp override |

## Verification
The bench builds the block with six comparators, three phases and a 5-bit error word. The word is wider than the minimum needed. This keeps the saturation codes (+15 and -16) clearly apart from the in-window range of +2 to -2. With six comparators there are enough inner bits to build non-monotonic codes. Some of these codes are inside the window. Others are below the window even though several bits are set. Three phases show that the clamp drives every phase, not only one.

// File: rtl/wadc_pkg.sv
package wadc_pkg;

  typedef enum logic [1:0] {
    Z_IN    = 2'd0,
    Z_ABOVE = 2'd1,
    Z_BELOW = 2'd2
  } zone_t;

  typedef enum logic [1:0] {
    CS_PASS = 2'd0,
    CS_OFF  = 2'd1,
    CS_ON   = 2'd2,
    CS_HOLD = 2'd3
  } clamp_st_t;

  // The top comparator wins, because turning the phases off is the safe choice.
  function automatic zone_t classify(input logic top_bit, input logic bot_bit);
    if (top_bit)       return Z_ABOVE;
    else if (!bot_bit) return Z_BELOW;
    else               return Z_IN;
  endfunction

  function automatic logic is_clamp(input clamp_st_t s);
    return (s == CS_OFF) || (s == CS_ON);
  endfunction

endpackage

// File: rtl/wadc_sync.sv
module wadc_sync #(
  parameter int W = 4,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  for (genvar k = 0; k < W; k++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q[k] <= RST_VAL[k];
        sync_q[k] <= RST_VAL[k];
      end else begin
        meta_q[k] <= d_i[k];
        sync_q[k] <= meta_q[k];
      end
    end
  end

  assign q_o = sync_q;

endmodule

// File: rtl/wadc_decode.sv
module wadc_decode
  import wadc_pkg::*;
#(
  parameter int NCMP  = 4,
  parameter int ERR_W = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NCMP-1:0]         code_i,
  input  zone_t                   zone_i,
  input  logic                    sample_i,
  output logic signed [ERR_W-1:0] err_o
);

  localparam int CNT_W  = $clog2(NCMP + 1);
  localparam int CENTER = NCMP / 2;
  localparam logic signed [ERR_W-1:0] ERR_MAX = {1'b0, {(ERR_W-1){1'b1}}};
  localparam logic signed [ERR_W-1:0] ERR_MIN = {1'b1, {(ERR_W-1){1'b0}}};

  logic [CNT_W-1:0]         ones_cnt;
  logic signed [ERR_W-1:0]  err_lin;
  logic signed [ERR_W-1:0]  err_nxt;
  logic signed [ERR_W-1:0]  err_q;

  // Ones count, so that a bubble in the thermometer code does not change the result.
  always_comb begin
    ones_cnt = '0;
    for (int k = 0; k < NCMP; k++) begin
      ones_cnt = ones_cnt + CNT_W'(code_i[k]);
    end
  end

  assign err_lin = $signed(ERR_W'(CENTER)) - $signed(ERR_W'(ones_cnt));

  always_comb begin
    unique case (zone_i)
      Z_ABOVE: err_nxt = ERR_MIN;
      Z_BELOW: err_nxt = ERR_MAX;
      default: err_nxt = err_lin;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        err_q <= '0;
    else if (sample_i) err_q <= err_nxt;
  end

  assign err_o = err_q;

endmodule

// File: rtl/wadc_clamp.sv
module wadc_clamp
  import wadc_pkg::*;
#(
  parameter int NPH = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  zone_t          zone_i,
  input  logic           period_i,
  input  logic [NPH-1:0] pwm_i,
  output logic [NPH-1:0] pwm_o,
  output clamp_st_t      st_o,
  output logic           release_o
);

  clamp_st_t st_q, st_d;
  logic      lvl_q, lvl_d;

  always_comb begin
    st_d  = st_q;
    lvl_d = lvl_q;
    unique case (zone_i)
      Z_ABOVE: begin
        st_d  = CS_OFF;
        lvl_d = 1'b0;
      end
      Z_BELOW: begin
        st_d  = CS_ON;
        lvl_d = 1'b1;
      end
      default: begin
        if (is_clamp(st_q))                      st_d = CS_HOLD;
        else if (st_q == CS_HOLD && period_i)    st_d = CS_PASS;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= CS_PASS;
      lvl_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      lvl_q <= lvl_d;
    end
  end

  // The hold ends in the boundary cycle itself, so the first period after the clamp is not shortened.
  assign release_o = (st_q == CS_HOLD) && period_i && (zone_i == Z_IN);

  for (genvar p = 0; p < NPH; p++) begin : g_phase
    always_comb begin
      if (st_q == CS_PASS || release_o) pwm_o[p] = pwm_i[p];
      else                              pwm_o[p] = lvl_q;
    end
  end

  assign st_o = st_q;

endmodule

// File: rtl/wadc_err_clamp.sv
module wadc_err_clamp
  import wadc_pkg::*;
#(
  parameter int NCMP  = 4,
  parameter int NPH   = 4,
  parameter int ERR_W = $clog2(NCMP + 1) + 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NCMP-1:0]         cmp_i,
  input  logic                    sample_i,
  input  logic [NPH-1:0]          pwm_i,
  input  logic                    period_i,
  output logic signed [ERR_W-1:0] err_o,
  output logic [NPH-1:0]          pwm_o
);

  localparam int CENTER = NCMP / 2;
  // The reset value is a mid-window code, so that no clamp fires while the synchronizers fill.
  localparam logic [NCMP-1:0] RST_CODE = NCMP'((64'd1 << CENTER) - 64'd1);

  logic [NCMP-1:0] cmp_sync;
  zone_t           zone_w;
  clamp_st_t       st_w;
  logic            release_w;

  wadc_sync #(.W(NCMP), .RST_VAL(RST_CODE)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (cmp_i),
    .q_o   (cmp_sync)
  );

  assign zone_w = classify(cmp_sync[NCMP-1], cmp_sync[0]);

  wadc_decode #(.NCMP(NCMP), .ERR_W(ERR_W)) u_dec (
    .clk      (clk),
    .rst_n    (rst_n),
    .code_i   (cmp_sync),
    .zone_i   (zone_w),
    .sample_i (sample_i),
    .err_o    (err_o)
  );

  wadc_clamp #(.NPH(NPH)) u_clamp (
    .clk       (clk),
    .rst_n     (rst_n),
    .zone_i    (zone_w),
    .period_i  (period_i),
    .pwm_i     (pwm_i),
    .pwm_o     (pwm_o),
    .st_o      (st_w),
    .release_o (release_w)
  );

endmodule

// File: rtl/wadc_err_clamp_chk.sv
module wadc_err_clamp_chk
  import wadc_pkg::*;
#(
  parameter int NCMP  = 4,
  parameter int NPH   = 4,
  parameter int ERR_W = 4
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    sample_i,
  input logic                    period_i,
  input logic signed [ERR_W-1:0] err_o,
  input logic [NPH-1:0]          pwm_o,
  input zone_t                   zone_w,
  input clamp_st_t               st_w
);

  localparam int CENTER = NCMP / 2;
  localparam logic signed [ERR_W-1:0] EMAX = {1'b0, {(ERR_W-1){1'b1}}};
  localparam logic signed [ERR_W-1:0] EMIN = {1'b1, {(ERR_W-1){1'b0}}};

  p_err_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_i |=> $stable(err_o));

  p_err_bounded_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_i && zone_w == Z_IN) |=>
      ($signed(err_o) <= CENTER - 1 && $signed(err_o) >= CENTER - (NCMP - 1)));

  p_sat_neg_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_i && zone_w == Z_ABOVE) |=> err_o == EMIN);

  p_sat_pos_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_i && zone_w == Z_BELOW) |=> err_o == EMAX);

  p_force_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    zone_w == Z_ABOVE |=> pwm_o == '0);

  p_force_on_r7: assert property (@(posedge clk) disable iff (!rst_n)
    zone_w == Z_BELOW |=> pwm_o == '1);

  p_hold_level_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_w == CS_HOLD && !period_i) |-> (pwm_o == '0 || pwm_o == '1));

  p_direct_swap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st_w == CS_OFF && zone_w == Z_BELOW) |=> st_w == CS_ON);

endmodule

bind wadc_err_clamp wadc_err_clamp_chk #(.NCMP(NCMP), .NPH(NPH), .ERR_W(ERR_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .sample_i (sample_i),
  .period_i (period_i),
  .err_o    (err_o),
  .pwm_o    (pwm_o),
  .zone_w   (zone_w),
  .st_w     (st_w)
);

// File: tb/wadc_err_clamp_test.sv
`timescale 1ns/1ps
module wadc_err_clamp_test;

  localparam int NCMP  = 6;
  localparam int NPH   = 3;
  localparam int ERR_W = 5;

  logic                    clk = 1'b0;
  logic                    rst_n = 1'b0;
  logic [NCMP-1:0]         cmp_i = 6'b000111;
  logic                    sample_i = 1'b0;
  logic [NPH-1:0]          pwm_i = 3'b000;
  logic                    period_i = 1'b0;
  logic signed [ERR_W-1:0] err_o;
  logic [NPH-1:0]          pwm_o;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  wadc_err_clamp #(.NCMP(NCMP), .NPH(NPH), .ERR_W(ERR_W)) uut (
    .clk(clk), .rst_n(rst_n), .cmp_i(cmp_i), .sample_i(sample_i),
    .pwm_i(pwm_i), .period_i(period_i), .err_o(err_o), .pwm_o(pwm_o)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Expected error inside the window: three minus the number of set bits.
  function automatic int model_err(input logic [NCMP-1:0] c);
    int n = 0;
    for (int k = 0; k < NCMP; k++) if (c[k]) n++;
    if (c[NCMP-1]) return -16;
    if (!c[0])     return 15;
    return 3 - n;
  endfunction

  task automatic set_cmp(input logic [NCMP-1:0] c);
    @(negedge clk);
    cmp_i = c;
    repeat (3) @(negedge clk);
  endtask

  task automatic take_sample(input string req);
    sample_i = 1'b1;
    @(negedge clk);
    sample_i = 1'b0;
    check(req, int'(err_o), model_err(cmp_i));
  endtask

  task automatic t_reset;
    pwm_i = 3'b101;
    #1;
    check("R1 err after reset", int'(err_o), 0);
    check("R1 pwm follows after reset", int'(pwm_o), 3'b101);
  endtask

  task automatic t_window;
    set_cmp(6'b000001); take_sample("R2 one bit set");
    set_cmp(6'b000111); take_sample("R2 three bits set");
    set_cmp(6'b011111); take_sample("R2 five bits set");
    set_cmp(6'b000001);
    repeat (4) @(negedge clk);
    check("R2 hold without sample", int'(err_o), -2);
  endtask

  task automatic t_nonmono;
    set_cmp(6'b010101); take_sample("R3 bubble code 010101");
    set_cmp(6'b011101); take_sample("R3 bubble code 011101");
  endtask

  task automatic t_pass;
    pwm_i = 3'b110; period_i = 1'b1; #1;
    check("R10 pass with period", int'(pwm_o), 3'b110);
    @(negedge clk); period_i = 1'b0; pwm_i = 3'b011; #1;
    check("R10 pass same cycle", int'(pwm_o), 3'b011);
  endtask

  task automatic t_above;
    pwm_i = 3'b111;
    @(negedge clk); cmp_i = 6'b100000;
    repeat (2) @(negedge clk);
    check("R6 not yet forced after two edges", int'(pwm_o), 3'b111);
    @(negedge clk);
    check("R6 forced off at third edge", int'(pwm_o), 0);
    take_sample("R4 saturate negative");
    check("R4 negative code", int'(err_o), -16);
  endtask

  task automatic t_swap_below;
    set_cmp(6'b011110);
    check("R9 direct off to on", int'(pwm_o), 3'b111);
    check("R7 forced on below", int'(pwm_o), 3'b111);
    take_sample("R5 saturate positive");
    check("R5 positive code", int'(err_o), 15);
  endtask

  task automatic t_release;
    pwm_i = 3'b010;
    set_cmp(6'b000111);
    repeat (3) @(negedge clk);
    check("R8 hold forced level", int'(pwm_o), 3'b111);
    period_i = 1'b1; #1;
    check("R8 release at boundary", int'(pwm_o), 3'b010);
    @(negedge clk); period_i = 1'b0; pwm_i = 3'b100; #1;
    check("R8 follows after boundary", int'(pwm_o), 3'b100);
    set_cmp(6'b100001);
    check("R6 off again", int'(pwm_o), 0);
    set_cmp(6'b000011);
    check("R8 hold off level", int'(pwm_o), 0);
    period_i = 1'b1; #1;
    check("R8 release off hold", int'(pwm_o), 3'b100);
    @(negedge clk); period_i = 1'b0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_window();
    t_nonmono();
    t_pass();
    t_above();
    t_swap_below();
    t_release();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule